// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register-facing half of an eight-line interrupt controller. A host reaches it through a byte-wide port with a single address bit. The block decodes the bytes written there into initialization words, mode commands and end-of-interrupt or rotation commands. It holds the state those commands set: the in-service register, the mask register, the rotation offset, the vector base and the mode flags. An internal priority resolver turns that state and the pending-request vector into one granted line.

The pending-request vector comes from a separate request-capture stage. This block never stores it. Instead it returns a one-cycle clear strobe for each line it consumes, whether through a processor acknowledge cycle or a poll read. The acknowledge cycle returns a vector byte formed from the base and the granted line. The processor request output is held low while an initialization sequence is still collecting bytes.

Top module: `irqc_cmd_decoder`

## Requirements
- R1: A write to address 0 with bit 4 set starts initialization. In the next cycle the in-service register, the mask, the rotation offset, the read-select, the poll, special-mask, rotate-on-auto-EOI, special-nested and auto-EOI flags are all zero. `int_req` stays low until the sequence returns to normal mode.
- R2: After that byte, the next address-1 write loads the vector base as the byte AND 0xF8. The following address-1 write is taken as the third word only when bit 1 of the starting byte was clear, and is otherwise skipped. A fourth word is taken only when bit 0 of the starting byte was set. The fourth word sets special nested mode from bit 4 and auto-EOI from bit 1. Once the last expected word is taken, the block is in normal mode.
- R3: In normal mode an address-1 write loads the mask register, and an address-1 read returns it. A set mask bit stops that line from being granted.
- R4: An address-0 write with bit 4 clear and bit 3 set is a mode command. If bit 1 is set, bit 0 selects what address-0 reads return: the in-service register (1) or the pending vector (0). If bit 6 is set, bit 5 becomes the special-mask flag. If bit 2 is set, the next read is a poll read.
- R5: A line is granted when it is the highest-priority unmasked pending line and it outranks every counted in-service line. Priority rank k belongs to line (offset + k) mod 8, and rank 0 is the highest. Under special nested mode, in-service line 2 is not counted. Under special mask, masked in-service lines are not counted.
- R6: During `inta` the `vector` output equals base + granted line, or base + 7 when nothing is granted. A granted acknowledge pulses that line on `irr_clr`, and it sets the line's in-service bit unless auto-EOI is on. A spurious acknowledge changes no state.
- R7: With auto-EOI on and rotate-on-auto-EOI on, an acknowledge sets the offset to line + 1 (mod 8) and leaves the in-service register unchanged.
- R8: Other address-0 writes are decoded from bits 7..5. Code 1 clears the highest-priority in-service bit under the current offset. Code 5 does the same and also sets the offset to that line + 1. Neither does anything when no bit is in service.
- R9: Code 3 clears the in-service bit of the line in bits 2..0. Code 7 clears that bit and sets the offset to line + 1. Code 6 only sets the offset to line + 1. Code 4 sets rotate-on-auto-EOI and code 0 clears it. Code 2 changes nothing.
- R10: A poll read returns 0x80 OR the granted line. It clears that line's in-service bit and pulses it on `irr_clr`. When no line is granted it returns 0x07 and changes nothing. Only the one read after the mode command is a poll read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| rd_en | input | 1 | Byte read strobe, one cycle per byte |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during `rd_en` |
| inta | input | 1 | Processor acknowledge strobe, one cycle |
| vector | output | 8 | Acknowledge vector, valid during `inta` |
| int_req | output | 1 | Interrupt request to the processor |
| irr_in | input | 8 | Pending-request vector from the capture stage |
| irr_clr | output | 8 | One-cycle clear strobe for consumed pending lines |

## Verification
`int_req`, `vector`, `rdata` and `irr_clr` are combinational from the registered state and the current strobe. Each is therefore due in the same cycle as its stimulus. Any change to the in-service register, the mask, the offset or the mode flags shows up in the cycle after the rising edge that takes the command. The bench drives inputs on the falling edge and compares all four outputs against its reference model 3 ns later. That sampling point falls after the edge that registered the previous command and before the next edge. Each directed read or acknowledge is also compared with a hand-worked literal inside that same window.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int RANK_W = LINE_W + 1;

  typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_st_t;

  // rank of the highest-priority set bit; LINES when none
  function automatic logic [RANK_W-1:0] prio_rank(input logic [LINES-1:0] m,
                                                   input logic [LINE_W-1:0] off);
    logic [RANK_W-1:0] r;
    r = RANK_W'(LINES);
    for (int p = LINES - 1; p >= 0; p--)
      if (m[LINE_W'(p) + off]) r = RANK_W'(p);
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] rank_to_line(input logic [RANK_W-1:0] r,
                                                     input logic [LINE_W-1:0] off);
    return r[LINE_W-1:0] + off;
  endfunction

  function automatic logic [7:0] vec_of(input logic [7:0] base,
                                        input logic [LINE_W-1:0] line);
    return {base[7:LINE_W], line};
  endfunction
endpackage

// File: rtl/irqc_resolver.sv
module irqc_resolver
  import irqc_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  logic [LINES-1:0]  pend,
  input  logic [LINES-1:0]  imr,
  input  logic [LINES-1:0]  isr,
  input  logic [LINE_W-1:0] off,
  input  logic              smm,
  input  logic              sfnm,
  output logic              valid,
  output logic [LINE_W-1:0] line
);
  logic [RANK_W-1:0] req_rank, cur_rank;
  logic [LINES-1:0]  isr_cnt;

  always_comb begin
    isr_cnt = isr;
    if (smm)  isr_cnt = isr_cnt & ~imr;
    if (sfnm) isr_cnt[CASC_LINE] = 1'b0;
    req_rank = prio_rank(pend & ~imr, off);
    cur_rank = prio_rank(isr_cnt, off);
    valid    = (req_rank < RANK_W'(LINES)) && (req_rank < cur_rank);
    line     = rank_to_line(req_rank, off);
  end
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_stb,
  input  logic     skip_w3,
  input  logic     want_w4,
  input  logic     data_stb,
  output init_st_t st,
  output logic     base_ld,
  output logic     mode_ld,
  output logic     mask_ld
);
  logic need3, need4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      need3 <= 1'b0;
      need4 <= 1'b0;
    end else if (start_stb) begin
      st    <= ST_W2;
      need3 <= ~skip_w3;
      need4 <= want_w4;
    end else if (data_stb) begin
      case (st)
        ST_W2:   st <= need3 ? ST_W3 : (need4 ? ST_W4 : ST_RUN);
        ST_W3:   st <= need4 ? ST_W4 : ST_RUN;
        ST_W4:   st <= ST_RUN;
        default: st <= ST_RUN;
      endcase
    end
  end

  assign base_ld = data_stb && (st == ST_W2);
  assign mode_ld = data_stb && (st == ST_W4);
  assign mask_ld = data_stb && (st == ST_RUN);

  // R2: the base word is always the one right after the start byte
  a_r2_start_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> (st == ST_W2));
  // R2: the fourth word ends the sequence
  a_r2_w4_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ld && !start_stb) |=> (st == ST_RUN));
endmodule

// File: rtl/irqc_eoi_dec.sv
module irqc_eoi_dec
  import irqc_pkg::*;
(
  input  logic              stb,
  input  logic [7:0]        cmd,
  input  logic [LINES-1:0]  isr,
  input  logic [LINE_W-1:0] off,
  output logic [LINES-1:0]  isr_clr,
  output logic              off_ld,
  output logic [LINE_W-1:0] off_val,
  output logic              raeoi_ld,
  output logic              raeoi_val
);
  logic [2:0]        code;
  logic [LINE_W-1:0] tgt, top_line;
  logic [RANK_W-1:0] top_rank;
  logic              any_isr;

  always_comb begin
    code      = cmd[7:5];
    tgt       = cmd[LINE_W-1:0];
    top_rank  = prio_rank(isr, off);
    any_isr   = top_rank < RANK_W'(LINES);
    top_line  = rank_to_line(top_rank, off);
    isr_clr   = '0;
    off_ld    = 1'b0;
    off_val   = '0;
    raeoi_ld  = 1'b0;
    raeoi_val = 1'b0;
    if (stb) begin
      case (code)
        3'd0, 3'd4: begin
          raeoi_ld  = 1'b1;
          raeoi_val = code[2];
        end
        3'd1, 3'd5: if (any_isr) begin
          isr_clr[top_line] = 1'b1;
          off_ld  = code[2];
          off_val = top_line + 1'b1;
        end
        3'd3: isr_clr[tgt] = 1'b1;
        3'd6: begin
          off_ld  = 1'b1;
          off_val = tgt + 1'b1;
        end
        3'd7: begin
          isr_clr[tgt] = 1'b1;
          off_ld  = 1'b1;
          off_val = tgt + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_cmd_decoder.sv
module irqc_cmd_decoder
  import irqc_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       inta,
  output logic [7:0] vector,
  output logic       int_req,
  input  logic [7:0] irr_in,
  output logic [7:0] irr_clr
);
  logic [LINES-1:0]  imr_q, isr_q;
  logic [LINE_W-1:0] off_q;
  logic [7:0]        base_q;
  logic rsel_isr_q, poll_arm_q, smm_q, raeoi_q, sfnm_q, aeoi_q;

  // named events
  logic wr0_stb, wr1_stb, icw1_stb, ocw3_stb, ocw2_stb, rd_stb, poll_take, ack_stb;
  assign ack_stb   = inta;
  assign wr0_stb   = wr_en && !addr && !inta;
  assign wr1_stb   = wr_en &&  addr && !inta;
  assign icw1_stb  = wr0_stb &&  wdata[4];
  assign ocw3_stb  = wr0_stb && !wdata[4] &&  wdata[3];
  assign ocw2_stb  = wr0_stb && !wdata[4] && !wdata[3];
  assign rd_stb    = rd_en && !wr_en && !inta;
  assign poll_take = rd_stb && poll_arm_q;

  logic              res_valid;
  logic [LINE_W-1:0] res_line;
  logic [LINES-1:0]  res_bit;

  irqc_resolver #(.CASC_LINE(CASC_LINE)) u_res (
    .pend(irr_in), .imr(imr_q), .isr(isr_q), .off(off_q),
    .smm(smm_q), .sfnm(sfnm_q), .valid(res_valid), .line(res_line)
  );

  always_comb begin
    res_bit = '0;
    res_bit[res_line] = 1'b1;
  end

  init_st_t init_st;
  logic     base_ld, mode_ld, mask_ld;

  irqc_init_seq u_init (
    .clk(clk), .rst_n(rst_n), .start_stb(icw1_stb), .skip_w3(wdata[1]),
    .want_w4(wdata[0]), .data_stb(wr1_stb), .st(init_st),
    .base_ld(base_ld), .mode_ld(mode_ld), .mask_ld(mask_ld)
  );

  logic [LINES-1:0]  eoi_clr;
  logic              eoi_off_ld, raeoi_ld, raeoi_val;
  logic [LINE_W-1:0] eoi_off_val;

  irqc_eoi_dec u_eoi (
    .stb(ocw2_stb), .cmd(wdata), .isr(isr_q), .off(off_q),
    .isr_clr(eoi_clr), .off_ld(eoi_off_ld), .off_val(eoi_off_val),
    .raeoi_ld(raeoi_ld), .raeoi_val(raeoi_val)
  );

  logic consume;
  assign consume = (ack_stb || poll_take) && res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0; isr_q <= '0; off_q <= '0; base_q <= '0;
      rsel_isr_q <= 1'b0; poll_arm_q <= 1'b0; smm_q <= 1'b0;
      raeoi_q <= 1'b0; sfnm_q <= 1'b0; aeoi_q <= 1'b0;
    end else if (icw1_stb) begin
      imr_q <= '0; isr_q <= '0; off_q <= '0;
      rsel_isr_q <= 1'b0; poll_arm_q <= 1'b0; smm_q <= 1'b0;
      raeoi_q <= 1'b0; sfnm_q <= 1'b0; aeoi_q <= 1'b0;
    end else begin
      if (ack_stb && res_valid) begin
        if (!aeoi_q)      isr_q <= isr_q | res_bit;
        else if (raeoi_q) off_q <= res_line + 1'b1;
      end
      if (poll_take) begin
        poll_arm_q <= 1'b0;
        if (res_valid) isr_q <= isr_q & ~res_bit;
      end
      if (ocw2_stb) begin
        isr_q <= isr_q & ~eoi_clr;
        if (eoi_off_ld) off_q   <= eoi_off_val;
        if (raeoi_ld)   raeoi_q <= raeoi_val;
      end
      if (ocw3_stb) begin
        if (wdata[2]) poll_arm_q <= 1'b1;
        if (wdata[1]) rsel_isr_q <= wdata[0];
        if (wdata[6]) smm_q      <= wdata[5];
      end
      if (base_ld) base_q <= wdata & 8'hF8;
      if (mode_ld) begin
        sfnm_q <= wdata[4];
        aeoi_q <= wdata[1];
      end
      if (mask_ld) imr_q <= wdata;
    end
  end

  assign int_req = res_valid && (init_st == ST_RUN);
  assign vector  = vec_of(base_q, res_valid ? res_line : LINE_W'(LINES - 1));
  assign irr_clr = consume ? res_bit : '0;

  always_comb begin
    if (poll_arm_q)  rdata = res_valid ? {1'b1, {(7-LINE_W){1'b0}}, res_line} : 8'h07;
    else if (addr)   rdata = imr_q;
    else if (rsel_isr_q) rdata = isr_q;
    else             rdata = irr_in;
  end

  // R1: start byte wipes the controller state and silences the request
  a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_stb |=> (isr_q == '0 && imr_q == '0 && off_q == '0 && !int_req));
  // R5: a granted line is pending and unmasked
  a_r5_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (irr_in[res_line] && !imr_q[res_line]));
  // R6: a granted acknowledge without auto-EOI marks the line in service
  a_r6_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && res_valid && !aeoi_q) |=> ((isr_q & $past(irr_clr)) != '0));
  // R7: rotating auto-EOI moves the offset and leaves in-service alone
  a_r7_auto_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && res_valid && aeoi_q && raeoi_q)
      |=> (isr_q == $past(isr_q) && off_q == LINE_W'($past(res_line) + 1'b1)));
  // R8: non-specific EOI retires exactly one in-service bit
  a_r8_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2_stb && wdata[6:5] == 2'b01 && isr_q != '0)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // R9: an EOI command clears at most one line
  a_r9_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    ocw2_stb |-> $onehot0(eoi_clr));
  // R10: a poll read is consumed by the read that uses it
  a_r10_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take |=> !poll_arm_q);
endmodule

// File: tb/irqc_cmd_decoder_tb_top.sv
module irqc_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] irr_in = 8'h00;
  logic [7:0] rdata, vector, irr_clr;
  logic       int_req;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  irqc_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .inta(inta), .vector(vector),
    .int_req(int_req), .irr_in(irr_in), .irr_clr(irr_clr)
  );

  // ---------------- reference model ----------------
  int m_imr, m_isr, m_off, m_base, m_st, m_n3, m_n4;
  bit m_rsel, m_poll, m_smm, m_raeoi, m_sfnm, m_aeoi;

  function automatic int rank_of(int m, int off);
    for (int k = 0; k < 8; k++)
      if ((m >> ((off + k) % 8)) & 1) return k;
    return 8;
  endfunction

  function automatic int m_pick();
    int pr, ir, ie;
    pr = rank_of(int'(irr_in) & ~m_imr & 255, m_off);
    ie = m_isr;
    if (m_smm)  ie = ie & ~m_imr;
    if (m_sfnm) ie = ie & ~4;
    ir = rank_of(ie, m_off);
    if (pr < 8 && pr < ir) return (pr + m_off) % 8;
    return -1;
  endfunction

  task automatic m_reset();
    m_imr = 0; m_isr = 0; m_off = 0; m_base = 0; m_st = 0; m_n3 = 0; m_n4 = 0;
    m_rsel = 0; m_poll = 0; m_smm = 0; m_raeoi = 0; m_sfnm = 0; m_aeoi = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    int l, k, c, t;
    if (rst_n) begin
      l = m_pick();
      if (inta) begin
        if (l >= 0) begin
          irr_in <= irr_in & ~(8'(1) << l);
          if (!m_aeoi) m_isr = m_isr | (1 << l);
          else if (m_raeoi) m_off = (l + 1) % 8;
        end
      end else if (wr_en && !addr) begin
        if (wdata[4]) begin
          m_imr = 0; m_isr = 0; m_off = 0; m_rsel = 0; m_poll = 0; m_smm = 0;
          m_raeoi = 0; m_sfnm = 0; m_aeoi = 0;
          m_st = 1; m_n3 = !wdata[1]; m_n4 = wdata[0];
        end else if (wdata[3]) begin
          if (wdata[2]) m_poll = 1;
          if (wdata[1]) m_rsel = wdata[0];
          if (wdata[6]) m_smm = wdata[5];
        end else begin
          c = wdata[7:5]; t = wdata[2:0];
          k = rank_of(m_isr, m_off);
          if (c == 0) m_raeoi = 0;
          else if (c == 4) m_raeoi = 1;
          else if ((c == 1 || c == 5) && k < 8) begin
            m_isr = m_isr & ~(1 << ((k + m_off) % 8));
            if (c == 5) m_off = ((k + m_off) % 8 + 1) % 8;
          end else if (c == 3) m_isr = m_isr & ~(1 << t);
          else if (c == 6) m_off = (t + 1) % 8;
          else if (c == 7) begin m_isr = m_isr & ~(1 << t); m_off = (t + 1) % 8; end
        end
      end else if (wr_en && addr) begin
        case (m_st)
          0: m_imr = wdata;
          1: begin m_base = wdata & 8'hF8; m_st = m_n3 ? 2 : (m_n4 ? 3 : 0); end
          2: m_st = m_n4 ? 3 : 0;
          default: begin m_sfnm = wdata[4]; m_aeoi = wdata[1]; m_st = 0; end
        endcase
      end else if (rd_en && m_poll) begin
        m_poll = 0;
        if (l >= 0) begin
          irr_in <= irr_in & ~(8'(1) << l);
          m_isr = m_isr & ~(1 << l);
        end
      end
    end
  end

  task automatic chk(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", t, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 3 ns after the falling edge
  always begin
    int l, e;
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      l = m_pick();
      chk({tag, " int_req"}, int'(int_req), (m_st == 0 && l >= 0) ? 1 : 0);
      chk({tag, " irr_clr"}, int'(irr_clr),
          ((inta || (rd_en && m_poll)) && l >= 0) ? (1 << l) : 0);
      if (inta) chk({tag, " vector"}, int'(vector), (m_base & 8'hF8) + (l >= 0 ? l : 7));
      if (rd_en && !inta && !wr_en) begin
        if (m_poll) e = (l >= 0) ? (8'h80 | l) : 8'h07;
        else if (addr) e = m_imr;
        else if (m_rsel) e = m_isr;
        else e = irr_in;
        chk({tag, " rdata"}, int'(rdata), e);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(bit a, int exp);
    @(negedge clk); rd_en = 1; addr = a;
    #3 chk({tag, " read literal"}, int'(rdata), exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ack(int exp);
    @(negedge clk); inta = 1;
    #3 chk({tag, " vector literal"}, int'(vector), exp);
    @(negedge clk); inta = 0;
  endtask

  task automatic raise(int l);
    @(negedge clk); irr_in = irr_in | (8'(1) << l);
  endtask

  task automatic req_is(int exp);
    @(negedge clk); #3 chk({tag, " int_req literal"}, int'(int_req), exp);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    tag = "R1"; rd(1, 8'h00); req_is(0);
    // R2 full four-word sequence, request held low meanwhile (R1)
    tag = "R2"; wr(0, 8'h11); wr(1, 8'h4D); wr(1, 8'h00);
    raise(3); tag = "R1"; req_is(0);
    tag = "R2"; wr(1, 8'h00); req_is(1);
    // R3 mask
    tag = "R3"; wr(1, 8'h08); req_is(0); rd(1, 8'h08); wr(1, 8'h00); req_is(1);
    // R6 acknowledge
    tag = "R6"; ack(8'h4B); req_is(0);
    // R4 read select
    tag = "R4"; wr(0, 8'h0B); rd(0, 8'h08); wr(0, 8'h0A); rd(0, 8'h00);
    // R5 priority against in-service
    tag = "R5"; raise(5); req_is(0); raise(1); req_is(1); ack(8'h49);
    // R8 non-specific EOI
    tag = "R8"; wr(0, 8'h20); req_is(0); wr(0, 8'h20); req_is(1); ack(8'h4D);
    // R9 specific EOI and rotation
    tag = "R9"; wr(0, 8'h65); wr(0, 8'hC4); raise(2); raise(6); ack(8'h4E);
    wr(0, 8'hE6); ack(8'h4A);
    tag = "R8"; wr(0, 8'hA0);
    tag = "R9"; wr(0, 8'h40); wr(0, 8'h0B); rd(0, 8'h00);
    tag = "R6"; ack(8'h4F); req_is(0);
    // R10 poll
    tag = "R10"; wr(0, 8'h0C); raise(0); rd(0, 8'h80); wr(0, 8'h0C); rd(1, 8'h07);
    rd(1, 8'h00);
    // R7 auto-EOI with rotation
    tag = "R7"; wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h02); wr(0, 8'h80);
    raise(4); ack(8'h24); wr(0, 8'h0B); rd(0, 8'h00);
    raise(4); raise(5); ack(8'h25); ack(8'h24);
    // R5 special nested mode
    tag = "R5"; wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h10);
    raise(2); ack(8'h22); raise(2); req_is(1); ack(8'h22);
    // R4 / R5 special mask
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h00);
    raise(1); ack(8'h21); raise(3); req_is(0);
    tag = "R4"; wr(1, 8'h02); wr(0, 8'h68); req_is(1); wr(0, 8'h48); req_is(0);
    // R2 short sequence, then mask write
    tag = "R2"; wr(0, 8'h12); wr(1, 8'h38); wr(1, 8'h01); rd(1, 8'h01);
    req_is(1); ack(8'h3B);
    // R1 start byte clears in-service
    tag = "R1"; wr(0, 8'h12); wr(1, 8'h38); wr(0, 8'h0B); rd(0, 8'h00);
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule